// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a two-level logic array whose function is held in a register-based personality. Four data inputs feed an AND plane that builds eight product terms. An OR plane then merges those terms into four outputs. The data path from `din` to `dout` is purely combinational. The only clocked parts are the personality registers and the gate that blanks the outputs during configuration.

The personality is written one product-term row per clock. A write supplies a row index, the AND-plane cell codes for that row and the OR-plane connection bits for that row. A write is accepted only while the configuration enable is high.

The `pal_mode` input selects the OR-plane topology:

- **Shared mode** (`pal_mode`=0): every term is available to every output through its OR bits. One term can feed several outputs at once.
- **Partitioned mode** (`pal_mode`=1): each output is hard-wired to its own group of four terms, and the OR bits are ignored.

Top module: `sop_logic_array`

## Requirements
- R1: Each AND-plane cell is 2 bits, and cell i sits at bits [2i+1:2i] of `cfg_and` and controls `din[i]`. Code 2'b01 uses the input true, 2'b10 uses it complemented, and 2'b00 leaves it out of the term.
- R2: A cell code of 2'b11 forces its product term to 0 for every `din` value.
- R3: A product term whose cells are all 2'b00 evaluates to 0. Its OR bits therefore never raise an output.
- R4: With `pal_mode`=0, bit k of a row's OR field connects that row's term to `dout[k]`. One term may drive several outputs.
- R5: With `pal_mode`=1, `dout[k]` is the OR of terms (4k+j) mod 8 for j = 0..3, and the OR bits have no effect. As a result, outputs 0 and 2 share terms 0..3, and outputs 1 and 3 share terms 4..7.
- R6: The personality below gives the listed functions in shared mode, with A=`din[2]`, B=`din[1]`, C=`din[0]` and `din[3]` unused. The outputs are F0=A+B'C', F1=AC'+AB, F2=B'C'+AB and F3=B'C+A.

  | Row | Term | OR bits |
  |-----|------|---------|
  | 0 | A | 4'b1001 |
  | 1 | AB | 4'b0110 |
  | 2 | AC' | 4'b0010 |
  | 3 | B'C' | 4'b0101 |
  | 4 | B'C | 4'b1000 |

- R7: On a rising clock edge with `cfg_en` and `cfg_we` both high, row `cfg_row` takes `cfg_and` and `cfg_or`. No other row changes.
- R8: A write strobe while `cfg_en` is low changes nothing.
- R9: `dout` is 0 while `cfg_en` is high. It stays 0 until the first rising edge after `cfg_en` falls, and from then on follows the new personality.
- R10: After reset, every row is cleared and `dout` is 0 for any `din`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_en | input | 1 | Configuration window; blanks the outputs |
| cfg_we | input | 1 | Row write strobe |
| cfg_row | input | 3 | Row (product term) index |
| cfg_and | input | 8 | AND-plane cell codes for the row |
| cfg_or | input | 4 | OR-plane connection bits for the row |
| pal_mode | input | 1 | 0 = shared terms, 1 = fixed term groups |
| din | input | 4 | Data inputs |
| dout | output | 4 | Sum-of-products outputs |

## Verification
The bench checks that a row with no programmed cells stays low even when its OR bits are all set. An array that treated an empty AND as true would raise every output.

It checks that a single 2'b11 cell kills a term whose other literals match. A design that read 2'b11 as "absent" would leave F0 and F3 high at the wrong inputs.

Partitioned mode is tested with a personality whose OR bits disagree with the fixed groups. A design that kept honouring the OR bits, or that failed to wrap outputs 2 and 3 back onto terms 0..7, would give different patterns.

The bench also checks the blanking cycle after the enable falls, and a write strobe given outside the configuration window. Getting either wrong shows up as a live output one cycle early, or as a silently changed row.

// File: rtl/sop_array_pkg.sv
package sop_array_pkg;

  typedef enum logic [1:0] {
    CELL_ABSENT = 2'b00,
    CELL_TRUE   = 2'b01,
    CELL_COMP   = 2'b10,
    CELL_KILL   = 2'b11
  } cell_t;

endpackage

// File: rtl/sop_cfg_store.sv
module sop_cfg_store #(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8,
  parameter int N_OUT  = 4,
  localparam int ROW_W = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [ROW_W-1:0]                   wr_row,
  input  logic [2*N_IN-1:0]                  wr_and,
  input  logic [N_OUT-1:0]                   wr_or,
  output logic [N_TERM-1:0][2*N_IN-1:0]      and_q,
  output logic [N_TERM-1:0][N_OUT-1:0]       or_q
);

  logic [N_TERM-1:0][2*N_IN-1:0] and_d;
  logic [N_TERM-1:0][N_OUT-1:0]  or_d;
  logic                          row_ok;

  assign row_ok = (int'(wr_row) < N_TERM);

  always_comb begin
    and_d = and_q;
    or_d  = or_q;
    if (wr_en && row_ok) begin
      and_d[wr_row] = wr_and;
      or_d[wr_row]  = wr_or;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      and_q <= '0;
      or_q  <= '0;
    end else if (wr_en) begin
      and_q <= and_d;
      or_q  <= or_d;
    end
  end

  // R7: the addressed row holds the written data after the edge
  a_r7_row_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (and_q[$past(wr_row)] == $past(wr_and)) &&
                     (or_q[$past(wr_row)]  == $past(wr_or)));

  // R8: without a write the personality does not move
  a_r8_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(and_q) && $stable(or_q));

endmodule

// File: rtl/sop_and_plane.sv
module sop_and_plane
  import sop_array_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int N_TERM = 8
) (
  input  logic [N_IN-1:0]                din,
  input  logic [N_TERM-1:0][2*N_IN-1:0]  and_cells,
  output logic [N_TERM-1:0]              term
);

  for (genvar t = 0; t < N_TERM; t++) begin : g_term
    logic [N_IN-1:0] lit_ok;
    logic [N_IN-1:0] used;
    logic [N_IN-1:0] kill_v;

    always_comb begin
      for (int i = 0; i < N_IN; i++) begin
        kill_v[i] = &and_cells[t][2*i +: 2];
        case (cell_t'(and_cells[t][2*i +: 2]))
          CELL_TRUE:   begin lit_ok[i] = din[i];  used[i] = 1'b1; end
          CELL_COMP:   begin lit_ok[i] = ~din[i]; used[i] = 1'b1; end
          CELL_ABSENT: begin lit_ok[i] = 1'b1;    used[i] = 1'b0; end
          default:     begin lit_ok[i] = 1'b0;    used[i] = 1'b1; end
        endcase
      end
    end

    assign term[t] = (|used) & (&lit_ok);

    // R2 / R3: dead or empty rows never raise their term
    always_comb begin
      a_r2_kill_cell: assert (!((|kill_v) && term[t]));
      a_r3_empty_row: assert ((|and_cells[t]) || !term[t]);
    end
  end

endmodule

// File: rtl/sop_or_plane.sv
module sop_or_plane #(
  parameter int N_TERM  = 8,
  parameter int N_OUT   = 4,
  parameter int PAL_GRP = 4
) (
  input  logic                           pal_mode,
  input  logic [N_TERM-1:0]              term,
  input  logic [N_TERM-1:0][N_OUT-1:0]   or_cells,
  output logic [N_OUT-1:0]               sum
);

  localparam int WRAP = N_TERM / PAL_GRP;

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [N_TERM-1:0] pla_col;
    logic [N_TERM-1:0] pal_col;
    logic [N_TERM-1:0] pick;

    always_comb begin
      pal_col = '0;
      for (int j = 0; j < PAL_GRP; j++) begin
        pal_col[(PAL_GRP*k + j) % N_TERM] = 1'b1;
      end
      for (int t = 0; t < N_TERM; t++) begin
        pla_col[t] = or_cells[t][k];
      end
    end

    assign pick   = pal_mode ? pal_col : pla_col;
    assign sum[k] = |(term & pick);

    // R5: outputs that wrap onto the same term group agree in fixed-group mode
    if ((N_TERM % PAL_GRP == 0) && (WRAP > 0) && (k + WRAP < N_OUT)) begin : g_wrap_chk
      always_comb begin
        a_r5_wrap_equal: assert (!pal_mode || (sum[k] == sum[k+WRAP]));
      end
    end
  end

endmodule

// File: rtl/sop_logic_array.sv
module sop_logic_array #(
  parameter int N_IN    = 4,
  parameter int N_TERM  = 8,
  parameter int N_OUT   = 4,
  parameter int PAL_GRP = 4,
  localparam int ROW_W  = (N_TERM > 1) ? $clog2(N_TERM) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_en,
  input  logic                 cfg_we,
  input  logic [ROW_W-1:0]     cfg_row,
  input  logic [2*N_IN-1:0]    cfg_and,
  input  logic [N_OUT-1:0]     cfg_or,
  input  logic                 pal_mode,
  input  logic [N_IN-1:0]      din,
  output logic [N_OUT-1:0]     dout
);

  logic [1:0]                    rst_pipe;
  logic                          rst_sync_n;
  logic                          hold_q;
  logic                          hold_d;
  logic                          wr_en;
  logic [N_TERM-1:0][2*N_IN-1:0] and_cells;
  logic [N_TERM-1:0][N_OUT-1:0]  or_cells;
  logic [N_TERM-1:0]             term;
  logic [N_OUT-1:0]              sum;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign wr_en  = cfg_en & cfg_we;
  assign hold_d = cfg_en;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) hold_q <= 1'b1;
    else             hold_q <= hold_d;
  end

  sop_cfg_store #(.N_IN(N_IN), .N_TERM(N_TERM), .N_OUT(N_OUT)) u_store (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .wr_en  (wr_en),
    .wr_row (cfg_row),
    .wr_and (cfg_and),
    .wr_or  (cfg_or),
    .and_q  (and_cells),
    .or_q   (or_cells)
  );

  sop_and_plane #(.N_IN(N_IN), .N_TERM(N_TERM)) u_and (
    .din       (din),
    .and_cells (and_cells),
    .term      (term)
  );

  sop_or_plane #(.N_TERM(N_TERM), .N_OUT(N_OUT), .PAL_GRP(PAL_GRP)) u_or (
    .pal_mode (pal_mode),
    .term     (term),
    .or_cells (or_cells),
    .sum      (sum)
  );

  assign dout = (cfg_en | hold_q) ? '0 : sum;

  // R9: outputs blank inside the window and on the edge where it closes
  a_r9_blank_in_window: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_en |-> (dout == '0));

  a_r9_blank_after_close: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(cfg_en) |-> (dout == '0));

endmodule

// File: tb/sop_logic_array_bench.sv
module sop_logic_array_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_en, cfg_we, pal_mode;
  logic [2:0] cfg_row;
  logic [7:0] cfg_and;
  logic [3:0] cfg_or;
  logic [3:0] din;
  logic [3:0] dout;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  sop_logic_array u_sop_logic_array (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
    .cfg_row(cfg_row), .cfg_and(cfg_and), .cfg_or(cfg_or),
    .pal_mode(pal_mode), .din(din), .dout(dout)
  );

  // Expected {F3,F2,F1,F0} for {A,B,C} = din[2:0]; R6
  localparam logic [3:0] REF_TBL [8] = '{
    4'b0101, 4'b1000, 4'b0000, 4'b0000,
    4'b1111, 4'b1001, 4'b1111, 4'b1111
  };

  task automatic check(input string req, input logic [3:0] exp);
    n_run++;
    if (dout !== exp) begin
      n_fail++;
      $display("FAIL %s din=%h actual=%b expected=%b", req, din, dout, exp);
    end
  endtask

  task automatic probe(input logic [3:0] d, input string req, input logic [3:0] exp);
    din = d;
    #1;
    check(req, exp);
  endtask

  task automatic write_row(input logic [2:0] r, input logic [7:0] a, input logic [3:0] o);
    @(negedge clk);
    cfg_en = 1'b1; cfg_we = 1'b1; cfg_row = r; cfg_and = a; cfg_or = o;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic close_window();
    @(negedge clk);
    cfg_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_en = 1'b0; cfg_we = 1'b0; pal_mode = 1'b0;
    cfg_row = '0; cfg_and = '0; cfg_or = '0; din = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10: cleared personality
    probe(4'hF, "R10", 4'b0000);
    probe(4'h4, "R10", 4'b0000);

    // R3: empty AND row with all OR bits set
    write_row(3'd5, 8'h00, 4'hF);
    close_window();
    probe(4'h0, "R3", 4'b0000);
    probe(4'h5, "R3", 4'b0000);
    probe(4'hF, "R3", 4'b0000);

    // R7 / R9: load reference personality, outputs blank meanwhile
    write_row(3'd0, 8'h10, 4'b1001);
    write_row(3'd1, 8'h14, 4'b0110);
    write_row(3'd2, 8'h12, 4'b0010);
    write_row(3'd3, 8'h0A, 4'b0101);
    write_row(3'd4, 8'h09, 4'b1000);
    probe(4'h4, "R9 in window", 4'b0000);
    @(negedge clk);
    cfg_en = 1'b0;
    #1;
    check("R9 cycle after close", 4'b0000);
    @(negedge clk);
    probe(4'h4, "R9 live", 4'b1111);

    // R1 / R4 / R6: reference functions, din[3] both ways
    for (int i = 0; i < 16; i++) begin
      probe(4'(i), "R6 R1 R4", REF_TBL[i % 8]);
    end

    // R5: fixed groups ignore OR bits and wrap
    pal_mode = 1'b1;
    probe(4'h0, "R5", 4'b0101);
    probe(4'h1, "R5", 4'b1010);
    probe(4'h4, "R5", 4'b0101);
    probe(4'h2, "R5", 4'b0000);
    pal_mode = 1'b0;
    probe(4'h5, "R4 back to shared", 4'b1001);

    // R8: strobe outside window
    @(negedge clk);
    cfg_we = 1'b1; cfg_row = 3'd0; cfg_and = 8'h00; cfg_or = 4'h0;
    @(negedge clk);
    cfg_we = 1'b0;
    probe(4'h4, "R8", 4'b1111);
    probe(4'h5, "R8", 4'b1001);

    // R2: kill code on the unused input kills term A
    write_row(3'd0, 8'hD0, 4'b1001);
    close_window();
    probe(4'h5, "R2", 4'b1000);
    probe(4'h4, "R2", 4'b0111);
    probe(4'hC, "R2", 4'b0111);

    // R7: rewrite restores only row 0
    write_row(3'd0, 8'h10, 4'b1001);
    close_window();
    probe(4'h5, "R7", 4'b1001);
    probe(4'h1, "R7", 4'b1000);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule